// File: doc/BRIEF.md
# Bit-Synchronous HDLC Frame Transmitter with Clear-to-Send Replay

This block sends HDLC frames bit by bit on a serial line timed by an external transmit clock. Every bit leaves on a falling edge of that clock. A byte source hands in one frame at a time over a valid/ready stream, and the last byte is marked. The block keeps the whole frame in a local replay store. It then sends an opening flag, the frame bytes and a 16-bit frame check sequence with zero insertion applied, and finally a closing flag.

A modem or line driver controls the flow with an active-low clear-to-send input. While clear-to-send is deasserted, the data line is held at mark (logic 1) and the bit sequence stops where it is. A deassertion of one bit time lets the frame continue from the held bit. A longer deassertion throws away the frame in progress. Once clear-to-send returns, the frame is sent again from its opening flag, using the stored copy. Request-to-send is driven low while a complete frame is held and not yet fully sent. A frame longer than the replay store is dropped and reported with a one-cycle error pulse.

All sequential logic runs on the falling edge of the transmit clock. The byte source must be synchronous to that clock.

Top module: `hdlc_sync_tx`

## Requirements
- R1: After reset, and whenever no frame is held, `txd` is 1, `rts_n` is 1, `src_ready` is 1 and `oversize_err` is 0.
- R2: Each transmission of a frame begins with the flag 0x7E, sent in time order as 0,1,1,1,1,1,1,0. Its first bit appears on the falling edge after the one that accepted the frame's last byte, provided `cts_n` is low.
- R3: Between the flags, the block sends a 0 after every five consecutive 1 bits. The run count restarts at each frame start and after each inserted 0. The flags themselves are never stuffed.
- R4: After the last data bit the block sends the one's complement of a CRC-16 (polynomial x^16+x^12+x^5+1, register preset 0xFFFF, data bits fed least significant first), least significant bit first. These 16 bits are stuffed like data, including a 0 that is needed right after the final check bit.
- R5: The closing flag 0x7E follows the check sequence. `rts_n` returns to 1 on the same edge that drives the flag's last bit.
- R6: On every falling edge where `cts_n` is high, `txd` becomes 1 and the frame does not advance. A frame that was loaded while `cts_n` was high starts only after `cts_n` goes low.
- R7: When `cts_n` is high for exactly one falling edge inside a frame, the next bit sent is the one that was due at that edge. No bit is lost or repeated.
- R8: When `cts_n` is high on two or more consecutive falling edges while a frame is being sent, the frame is abandoned. Once `cts_n` is low again, the block sends it again in full, starting from the opening flag.
- R9: `rts_n` goes to 0 on the edge that accepts a frame's last byte. It stays 0 until that frame's closing flag has been sent.
- R10: A frame of up to BUF_DEPTH bytes is sent. When a byte arrives while BUF_DEPTH bytes are already stored, `oversize_err` pulses for exactly one cycle. The rest of that frame, up to and including its last byte, is accepted and discarded, and nothing is sent.
- R11: `src_ready` is 1 only while no complete frame is held. While a frame is being sent, the source is held off.
- R12: Within each byte, bits go out least significant first. Bytes go out in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Byte source holds a valid byte |
| src_data | input | 8 | Frame byte |
| src_last | input | 1 | Marks the final byte of a frame |
| src_ready | output | 1 | Block can accept a byte |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial transmit data |
| rts_n | output | 1 | Request-to-send, active low, while a frame is pending |
| oversize_err | output | 1 | One-cycle pulse when a frame exceeds the replay store |

## Verification
The hardest conditions to reach from the ports are the clear-to-send cases that depend on exact timing. One is a deassertion that lasts exactly one edge and must not lose a bit. Others are an abort that lands inside the closing flag, and a stuffed zero needed right after the final check bit. The stimulus raises `cts_n` at counted cycle offsets after a frame is loaded, choosing offsets that fall in the opening flag, the data, the check bits and the closing flag. It also sends a long run of random frames back to back, which makes a trailing stuffed zero likely. Overflow is covered by frames one byte over, exactly at, and several bytes over the store size.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   localparam logic [7:0]  FLAG_PATTERN  = 8'h7E;
   localparam int unsigned STUFF_RUN     = 5;
   localparam logic [15:0] FCS_POLY_REFL = 16'h8408;
   localparam logic [15:0] FCS_PRESET    = 16'hFFFF;

   typedef enum logic [2:0] {
      ST_LOAD,
      ST_DROP,
      ST_OPEN,
      ST_BODY,
      ST_CLOSE
   } tx_state_e;

   typedef enum logic [1:0] {
      PH_DATA,
      PH_FCS,
      PH_TAIL
   } body_phase_e;

   // One serial step of the reflected CRC register.
   function automatic logic [15:0] fcs_step(input logic [15:0] crc,
                                            input logic        bit_in,
                                            input logic [15:0] poly);
      logic fb;
      fb = crc[0] ^ bit_in;
      return {1'b0, crc[15:1]} ^ (fb ? poly : 16'h0000);
   endfunction

endpackage

// File: rtl/hdlc_replay_buf.sv
module hdlc_replay_buf #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              tx_clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [BYTE_W-1:0] rd_data
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("hdlc_replay_buf: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0][BYTE_W-1:0] store;

   // One register bank per entry, each with its own write decode.
   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic [BYTE_W-1:0] q;
      always_ff @(negedge tx_clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && (wr_addr == AW'(e))) begin
            q <= wr_data;
         end
      end
      assign store[e] = q;
   end

   assign rd_data = store[rd_addr];

endmodule

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16
   import hdlc_tx_pkg::*;
#(
   parameter logic [15:0] POLY   = FCS_POLY_REFL,
   parameter logic [15:0] PRESET = FCS_PRESET
) (
   input  logic tx_clk,
   input  logic rst_n,
   input  logic preset,
   input  logic absorb,
   input  logic bit_in,
   input  logic emit,
   output logic fcs_bit
);

   logic [15:0] crc_q;

   always_ff @(negedge tx_clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= PRESET;
      end else if (preset) begin
         crc_q <= PRESET;
      end else if (absorb) begin
         crc_q <= fcs_step(crc_q, bit_in, POLY);
      end else if (emit) begin
         crc_q <= {1'b1, crc_q[15:1]};
      end
   end

   // Check bits leave complemented, low bit first.
   assign fcs_bit = ~crc_q[0];

   // R4: the register either takes in a data bit or shifts out a check bit, never both.
   a_r4_single_op: assert property (@(negedge tx_clk) disable iff (!rst_n)
      absorb |-> !emit);

   // R4: a preset from the opening flag leaves the preset value.
   a_r4_preset_value: assert property (@(negedge tx_clk) disable iff (!rst_n)
      preset |=> (crc_q == PRESET));

endmodule

// File: rtl/hdlc_cts_watch.sv
module hdlc_cts_watch #(
   parameter int unsigned ABORT_TICKS = 2,
   localparam int unsigned CW = (ABORT_TICKS > 1) ? $clog2(ABORT_TICKS) : 1
) (
   input  logic tx_clk,
   input  logic rst_n,
   input  logic cts_n,
   input  logic active,
   output logic abort
);

   generate
      if (ABORT_TICKS < 2) begin : g_bad_ticks
         $error("hdlc_cts_watch: ABORT_TICKS must be at least 2");
      end

      if (ABORT_TICKS == 2) begin : g_one_flop
         logic prev_hi;
         always_ff @(negedge tx_clk or negedge rst_n) begin
            if (!rst_n) prev_hi <= 1'b0;
            else        prev_hi <= cts_n;
         end
         assign abort = active && cts_n && prev_hi;

         // R8: an abort needs clear-to-send high on the previous edge too.
         a_r8_hold_before_abort: assert property (@(negedge tx_clk) disable iff (!rst_n)
            abort |-> $past(cts_n));
      end else begin : g_counter
         logic [CW-1:0] hi_cnt;
         always_ff @(negedge tx_clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_cnt <= '0;
            end else if (!cts_n) begin
               hi_cnt <= '0;
            end else if (hi_cnt != CW'(ABORT_TICKS - 1)) begin
               hi_cnt <= hi_cnt + 1'b1;
            end
         end
         assign abort = active && cts_n && (hi_cnt == CW'(ABORT_TICKS - 1));
      end
   endgenerate

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
   import hdlc_tx_pkg::*;
#(
   parameter int unsigned BUF_DEPTH = 64,
   localparam int unsigned AW    = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
   localparam int unsigned CNT_W = AW + 1
) (
   input  logic          tx_clk,
   input  logic          rst_n,
   input  logic          src_valid,
   input  logic [7:0]    src_data,
   input  logic          src_last,
   output logic          src_ready,
   input  logic          cts_n,
   input  logic          abort,
   output logic          in_frame,
   output logic          buf_wr_en,
   output logic [AW-1:0] buf_wr_addr,
   output logic [7:0]    buf_wr_data,
   output logic [AW-1:0] buf_rd_addr,
   input  logic [7:0]    buf_rd_data,
   output logic          fcs_preset,
   output logic          fcs_absorb,
   output logic          fcs_in,
   output logic          fcs_emit,
   input  logic          fcs_bit,
   output logic          txd,
   output logic          rts_n,
   output logic          oversize_err
);

   tx_state_e     state;
   body_phase_e   phase;
   logic [CNT_W-1:0] wr_cnt;
   logic [AW-1:0] last_idx;
   logic [AW-1:0] rd_ptr;
   logic [2:0]    bit_idx;
   logic [3:0]    fcs_cnt;
   logic [2:0]    ones;
   logic          txd_q;
   logic          err_q;

   logic          store_full;
   logic          take_byte;
   logic          stuff_now;
   logic          data_bit;
   logic          cur_bit;
   logic [2:0]    ones_nxt;
   logic          sending;

   assign store_full = (wr_cnt == CNT_W'(BUF_DEPTH));
   assign take_byte  = (state == ST_LOAD) && src_valid && !store_full;
   assign in_frame   = (state == ST_OPEN) || (state == ST_BODY) || (state == ST_CLOSE);
   assign sending    = in_frame && !cts_n;
   assign stuff_now  = (ones == 3'(STUFF_RUN));
   assign data_bit   = buf_rd_data[bit_idx];
   assign cur_bit    = (phase == PH_DATA) ? data_bit : fcs_bit;
   assign ones_nxt   = cur_bit ? ones + 3'd1 : 3'd0;

   assign src_ready   = (state == ST_LOAD) || (state == ST_DROP);
   assign buf_wr_en   = take_byte;
   assign buf_wr_addr = wr_cnt[AW-1:0];
   assign buf_wr_data = src_data;
   assign buf_rd_addr = rd_ptr;

   assign fcs_preset = (state == ST_OPEN);
   assign fcs_absorb = sending && (state == ST_BODY) && !stuff_now && (phase == PH_DATA);
   assign fcs_emit   = sending && (state == ST_BODY) && !stuff_now && (phase == PH_FCS);
   assign fcs_in     = data_bit;

   assign txd          = txd_q;
   assign rts_n        = !in_frame;
   assign oversize_err = err_q;

   always_ff @(negedge tx_clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_LOAD;
         phase    <= PH_DATA;
         wr_cnt   <= '0;
         last_idx <= '0;
         rd_ptr   <= '0;
         bit_idx  <= '0;
         fcs_cnt  <= '0;
         ones     <= '0;
         txd_q    <= 1'b1;
         err_q    <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (state)
            ST_LOAD: begin
               txd_q <= 1'b1;
               if (src_valid) begin
                  if (store_full) begin
                     err_q  <= 1'b1;
                     wr_cnt <= '0;
                     if (!src_last) state <= ST_DROP;
                  end else if (src_last) begin
                     last_idx <= wr_cnt[AW-1:0];
                     wr_cnt   <= '0;
                     bit_idx  <= '0;
                     state    <= ST_OPEN;
                  end else begin
                     wr_cnt <= wr_cnt + 1'b1;
                  end
               end
            end
            ST_DROP: begin
               txd_q <= 1'b1;
               if (src_valid && src_last) state <= ST_LOAD;
            end
            default: begin
               if (abort) begin
                  txd_q   <= 1'b1;
                  state   <= ST_OPEN;
                  bit_idx <= '0;
               end else if (cts_n) begin
                  txd_q <= 1'b1;
               end else begin
                  unique case (state)
                     ST_OPEN: begin
                        txd_q   <= FLAG_PATTERN[bit_idx];
                        bit_idx <= bit_idx + 3'd1;
                        if (bit_idx == 3'd7) begin
                           state  <= ST_BODY;
                           phase  <= PH_DATA;
                           rd_ptr <= '0;
                           ones   <= '0;
                        end
                     end
                     ST_BODY: begin
                        if (stuff_now) begin
                           txd_q <= 1'b0;
                           ones  <= '0;
                           if (phase == PH_TAIL) begin
                              state   <= ST_CLOSE;
                              bit_idx <= '0;
                           end
                        end else if (phase == PH_DATA) begin
                           txd_q   <= data_bit;
                           ones    <= ones_nxt;
                           bit_idx <= bit_idx + 3'd1;
                           if (bit_idx == 3'd7) begin
                              if (rd_ptr == last_idx) begin
                                 phase   <= PH_FCS;
                                 fcs_cnt <= '0;
                              end else begin
                                 rd_ptr <= rd_ptr + 1'b1;
                              end
                           end
                        end else begin
                           txd_q   <= fcs_bit;
                           ones    <= ones_nxt;
                           fcs_cnt <= fcs_cnt + 4'd1;
                           if (fcs_cnt == 4'd15) begin
                              if (ones_nxt == 3'(STUFF_RUN)) begin
                                 phase <= PH_TAIL;
                              end else begin
                                 state   <= ST_CLOSE;
                                 bit_idx <= '0;
                              end
                           end
                        end
                     end
                     default: begin
                        txd_q   <= FLAG_PATTERN[bit_idx];
                        bit_idx <= bit_idx + 3'd1;
                        if (bit_idx == 3'd7) state <= ST_LOAD;
                     end
                  endcase
               end
            end
         endcase
      end
   end

   // R6: a high clear-to-send puts mark on the line at the same edge.
   a_r6_mark_on_hold: assert property (@(negedge tx_clk) disable iff (!rst_n)
      cts_n |=> txd_q);

   // R3: five ones in the frame body force an inserted zero.
   a_r3_zero_after_five: assert property (@(negedge tx_clk) disable iff (!rst_n)
      (state == ST_BODY && stuff_now && !cts_n) |=> !txd_q);

   // R2: the first flag bit leaves as a zero.
   a_r2_open_first_zero: assert property (@(negedge tx_clk) disable iff (!rst_n)
      (state == ST_OPEN && bit_idx == 3'd0 && !cts_n) |=> !txd_q);

   // R8: an abort rewinds to the start of the opening flag.
   a_r8_abort_rewinds: assert property (@(negedge tx_clk) disable iff (!rst_n)
      abort |=> (state == ST_OPEN && bit_idx == 3'd0));

   // R9: the edge that takes a frame's last byte raises the request.
   a_r9_request_after_load: assert property (@(negedge tx_clk) disable iff (!rst_n)
      (take_byte && src_last) |=> !rts_n);

   // R10: the overflow indication lasts one cycle.
   a_r10_single_pulse: assert property (@(negedge tx_clk) disable iff (!rst_n)
      err_q |=> !err_q);

endmodule

// File: rtl/hdlc_sync_tx.sv
module hdlc_sync_tx #(
   parameter int unsigned BUF_DEPTH   = 64,
   parameter int unsigned ABORT_TICKS = 2,
   localparam int unsigned AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
   input  logic       tx_clk,
   input  logic       rst_n,
   input  logic       src_valid,
   input  logic [7:0] src_data,
   input  logic       src_last,
   output logic       src_ready,
   input  logic       cts_n,
   output logic       txd,
   output logic       rts_n,
   output logic       oversize_err
);

   generate
      if (BUF_DEPTH < 2) begin : g_bad_buf
         $error("hdlc_sync_tx: BUF_DEPTH must be at least 2");
      end
      if (ABORT_TICKS < 2) begin : g_bad_abort
         $error("hdlc_sync_tx: ABORT_TICKS must be at least 2");
      end
   endgenerate

   logic          in_frame;
   logic          abort;
   logic          buf_wr_en;
   logic [AW-1:0] buf_wr_addr;
   logic [7:0]    buf_wr_data;
   logic [AW-1:0] buf_rd_addr;
   logic [7:0]    buf_rd_data;
   logic          fcs_preset;
   logic          fcs_absorb;
   logic          fcs_in;
   logic          fcs_emit;
   logic          fcs_bit;

   hdlc_replay_buf #(.DEPTH(BUF_DEPTH), .BYTE_W(8)) u_buf (
      .tx_clk  (tx_clk),
      .rst_n   (rst_n),
      .wr_en   (buf_wr_en),
      .wr_addr (buf_wr_addr),
      .wr_data (buf_wr_data),
      .rd_addr (buf_rd_addr),
      .rd_data (buf_rd_data)
   );

   hdlc_fcs16 u_fcs (
      .tx_clk  (tx_clk),
      .rst_n   (rst_n),
      .preset  (fcs_preset),
      .absorb  (fcs_absorb),
      .bit_in  (fcs_in),
      .emit    (fcs_emit),
      .fcs_bit (fcs_bit)
   );

   hdlc_cts_watch #(.ABORT_TICKS(ABORT_TICKS)) u_cts (
      .tx_clk (tx_clk),
      .rst_n  (rst_n),
      .cts_n  (cts_n),
      .active (in_frame),
      .abort  (abort)
   );

   hdlc_tx_framer #(.BUF_DEPTH(BUF_DEPTH)) u_framer (
      .tx_clk       (tx_clk),
      .rst_n        (rst_n),
      .src_valid    (src_valid),
      .src_data     (src_data),
      .src_last     (src_last),
      .src_ready    (src_ready),
      .cts_n        (cts_n),
      .abort        (abort),
      .in_frame     (in_frame),
      .buf_wr_en    (buf_wr_en),
      .buf_wr_addr  (buf_wr_addr),
      .buf_wr_data  (buf_wr_data),
      .buf_rd_addr  (buf_rd_addr),
      .buf_rd_data  (buf_rd_data),
      .fcs_preset   (fcs_preset),
      .fcs_absorb   (fcs_absorb),
      .fcs_in       (fcs_in),
      .fcs_emit     (fcs_emit),
      .fcs_bit      (fcs_bit),
      .txd          (txd),
      .rts_n        (rts_n),
      .oversize_err (oversize_err)
   );

   // R5: the request drops away on the edge of the closing flag's final zero.
   a_r5_release_on_last_zero: assert property (@(negedge tx_clk) disable iff (!rst_n)
      $rose(rts_n) |-> !txd);

   // R11: the source is never offered space while a frame is pending.
   a_r11_ready_only_idle: assert property (@(negedge tx_clk) disable iff (!rst_n)
      src_ready |-> rts_n);

endmodule

// File: tb/test_hdlc_sync_tx.sv
`timescale 1ns/1ps
module test_hdlc_sync_tx;

   localparam int DEPTH = 16;
   localparam int ABT   = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       src_valid = 1'b0;
   logic [7:0] src_data = 8'h00;
   logic       src_last = 1'b0;
   logic       cts_n = 1'b0;
   logic       src_ready;
   logic       txd;
   logic       rts_n;
   logic       oversize_err;

   always #4 clk = ~clk;

   hdlc_sync_tx #(.BUF_DEPTH(DEPTH), .ABORT_TICKS(ABT)) i_hdlc_sync_tx (
      .tx_clk       (clk),
      .rst_n        (rst_n),
      .src_valid    (src_valid),
      .src_data     (src_data),
      .src_last     (src_last),
      .src_ready    (src_ready),
      .cts_n        (cts_n),
      .txd          (txd),
      .rts_n        (rts_n),
      .oversize_err (oversize_err)
   );

   int    n_tests = 0;
   int    n_fails = 0;
   int    cyc = 0;
   string cur_req = "R1";

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
   endtask

   // ---------------- behavioural reference model ----------------
   bit         stream_q[$];
   logic [7:0] m_bytes[$];
   int         pos = 0;
   int         hi_m = 0;
   bit         m_send = 0;
   bit         m_drop = 0;
   bit         exp_txd = 1, exp_rts = 1, exp_ready = 1, exp_err = 0;

   function automatic void build_stream();
      bit          body[$];
      logic [15:0] c = 16'hFFFF;
      int          run = 0;
      bit          fb;
      stream_q.delete();
      foreach (m_bytes[k]) begin
         for (int i = 0; i < 8; i++) begin
            body.push_back(m_bytes[k][i]);
            fb = c[0] ^ m_bytes[k][i];
            c  = c >> 1;
            if (fb) c = c ^ 16'h8408;
         end
      end
      for (int i = 0; i < 16; i++) body.push_back(~c[i]);
      for (int i = 0; i < 8; i++) stream_q.push_back(8'h7E >> i);
      foreach (body[k]) begin
         if (run == 5) begin stream_q.push_back(1'b0); run = 0; end
         stream_q.push_back(body[k]);
         run = body[k] ? run + 1 : 0;
      end
      if (run == 5) stream_q.push_back(1'b0);
      for (int i = 0; i < 8; i++) stream_q.push_back(8'h7E >> i);
   endfunction

   always @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_send = 0; m_drop = 0; pos = 0; hi_m = 0; m_bytes.delete();
         exp_txd = 1; exp_rts = 1; exp_ready = 1; exp_err = 0;
      end else begin
         exp_err = 0;
         if (m_send) begin
            if (cts_n) begin
               exp_txd = 1;
               if (hi_m >= ABT - 1) pos = 0;
            end else begin
               exp_txd = stream_q[pos];
               pos++;
               if (pos == stream_q.size()) m_send = 0;
            end
         end else begin
            exp_txd = 1;
            if (src_valid) begin
               if (m_drop) begin
                  if (src_last) m_drop = 0;
               end else if (m_bytes.size() == DEPTH) begin
                  exp_err = 1;
                  m_bytes.delete();
                  if (!src_last) m_drop = 1;
               end else begin
                  m_bytes.push_back(src_data);
                  if (src_last) begin
                     build_stream();
                     m_bytes.delete();
                     m_send = 1;
                     pos = 0;
                  end
               end
            end
         end
         hi_m = cts_n ? ((hi_m < 100) ? hi_m + 1 : hi_m) : 0;
         exp_rts   = !m_send;
         exp_ready = !m_send;
      end
   end

   // Compare on every cycle, mid-period.
   always @(posedge clk) begin
      if (rst_n) begin
         check(txd == exp_txd, cur_req, "txd", txd, exp_txd);
         check(rts_n == exp_rts, "R9", "rts_n", rts_n, exp_rts);
         check(src_ready == exp_ready, "R11", "src_ready", src_ready, exp_ready);
         check(oversize_err == exp_err, "R10", "oversize_err", oversize_err, exp_err);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_tests++;
         n_fails++;
         $display("FAIL watchdog: actual=%0d cycles expected=below 150000", cyc);
         report();
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   logic [7:0] fq[$];

   task automatic add(input logic [7:0] b);
      fq.push_back(b);
   endtask

   task automatic send_frame();
      for (int i = 0; i < fq.size(); i++) begin
         @(posedge clk);
         src_valid = 1'b1;
         src_data  = fq[i];
         src_last  = (i == fq.size() - 1);
         while (!src_ready) @(posedge clk);
         @(negedge clk);
      end
      @(posedge clk);
      src_valid = 1'b0;
      src_last  = 1'b0;
      fq.delete();
   endtask

   task automatic wait_idle();
      @(posedge clk);
      while (!rts_n) @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (5) @(posedge clk);
      // R1: reset values seen at the ports while reset is held
      check(txd == 1'b1, "R1", "txd in reset", txd, 1);
      check(rts_n == 1'b1, "R1", "rts_n in reset", rts_n, 1);
      check(src_ready == 1'b1, "R1", "src_ready in reset", src_ready, 1);
      check(oversize_err == 1'b0, "R1", "oversize_err in reset", oversize_err, 0);
      rst_n = 1'b1;
      repeat (10) @(posedge clk);

      cur_req = "R2";
      add(8'h00); send_frame(); wait_idle();

      cur_req = "R12";
      add(8'h01); add(8'h80); add(8'h35); send_frame(); wait_idle();

      cur_req = "R3";
      for (int i = 0; i < 6; i++) add(8'hFF);
      send_frame(); wait_idle();
      add(8'h1F); add(8'hF8); add(8'h7C); send_frame(); wait_idle();

      cur_req = "R4";
      for (int f = 0; f < 30; f++) begin
         int len = 1 + ($urandom % DEPTH);
         for (int i = 0; i < len; i++) add(8'($urandom));
         send_frame();
      end
      wait_idle();

      cur_req = "R5";
      add(8'h7E); add(8'h7D); send_frame(); wait_idle();

      cur_req = "R6";
      @(posedge clk); cts_n = 1'b1;
      add(8'hA5); add(8'h3C); send_frame();
      repeat (6) @(posedge clk);
      cts_n = 1'b0;
      wait_idle();

      cur_req = "R7";
      for (int k = 0; k < 5; k++) begin
         int off = 2 + 11 * k;
         for (int i = 0; i < 6; i++) add(8'($urandom));
         send_frame();
         repeat (off) @(posedge clk);
         cts_n = 1'b1;
         @(posedge clk);
         cts_n = 1'b0;
         wait_idle();
      end

      cur_req = "R8";
      for (int k = 0; k < 4; k++) begin
         int off = 4 + 12 * k;
         add(8'h00);
         send_frame();
         repeat (off) @(posedge clk);
         cts_n = 1'b1;
         repeat (2 + k) @(posedge clk);
         cts_n = 1'b0;
         wait_idle();
      end
      for (int i = 0; i < 8; i++) add(8'($urandom));
      send_frame();
      repeat (40) @(posedge clk);
      cts_n = 1'b1;
      repeat (3) @(posedge clk);
      cts_n = 1'b0;
      wait_idle();

      cur_req = "R10";
      for (int i = 0; i < DEPTH + 3; i++) add(8'($urandom));
      send_frame(); wait_idle();
      for (int i = 0; i < DEPTH; i++) add(8'($urandom));
      send_frame(); wait_idle();
      for (int i = 0; i < DEPTH + 1; i++) add(8'hFF);
      send_frame(); wait_idle();
      add(8'h42); send_frame(); wait_idle();

      cur_req = "R11";
      add(8'h11); add(8'h22); send_frame();
      cts_n = 1'b1;
      add(8'h33); add(8'h44); add(8'h55);
      fork
         send_frame();
         begin
            repeat (4) @(posedge clk);
            cts_n = 1'b0;
         end
      join
      wait_idle();

      repeat (5) @(posedge clk);
      report();
      $finish;
   end

endmodule